// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

This block is a word-addressed GPIO controller for up to 32 pins. Software sets each pin as a driven output or a sampled input, writes output levels, and reads back the current pin states. Each pin can also raise an interrupt. Three configuration bit-planes choose the trigger for each pin: level or edge, polarity, and edge on both transitions. The per-pin interrupt conditions are gated by an enable mask and merged into a single interrupt line.

Pin inputs pass through a two-flop synchronizer before any use. For a pin in edge mode, a detected edge sets a sticky flag that only a write-one clear removes. For a pin in level mode, the condition simply follows the synchronized level, so a clear has no lasting effect while the level is active. A read-only version word reports whether detection on both edges is present.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the direction register reads all ones for the implemented pins (all inputs). Every other writable register reads zero, and the interrupt output is low.
- R2: A direction bit of 1 makes a pin an input (its `pin_oe` bit is 0). A direction bit of 0 makes it an output: `pin_oe` is 1 and `pin_out` carries the value written at byte offset 0x00. The direction register sits at 0x04, and a register only changes on a write to its own offset.
- R3: A read at offset 0x00 returns, for input pins, the pin input as it was two clock edges earlier, and for output pins, the level being driven.
- R4: With the mode bit (offset 0x18) at 0 the pin is level-triggered. Its status bit (offset 0x0C) follows the synchronized pin when the polarity bit (offset 0x1C) is 1, and its inverse when the polarity bit is 0. A clear does not drop it while the level stays active.
- R5: With the mode bit at 1 and the both-edge bit clear, a rising edge (polarity 1) or a falling edge (polarity 0) of the synchronized pin sets a sticky status bit. The status bit appears one cycle after the synchronized value changes. The opposite edge leaves it unchanged.
- R6: With the mode bit and the both-edge bit (offset 0x24) both at 1, either edge sets the sticky status bit.
- R7: Writing ones to offset 0x14 clears the matching edge status bits, and zero bits have no effect. An edge detected in the same cycle as the clear wins, and the bit stays set.
- R8: The pending word at 0x10 equals status AND enable (enable at 0x08). The interrupt output is the OR of the pending bits. Writing zero to the enable register masks the output without changing status.
- R9: Offset 0x20 reads the constant 3. Writes to status, pending and version are ignored. Register bits at or above the pin count read as zero.
- R10: A read of an offset with no register, or of a byte address that is not word aligned, returns zero. A write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output levels |
| pin_oe | output | NUM_PINS | Output enables, 1 = driven |
| irq | output | 1 | Merged interrupt |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a new edge detection. The bench counts the edges from a pin change: the first synchronizer stage, the second stage, then the flag update. It places the clear strobe two falling edges after the pin moves, so the clear is sampled on the same edge that captures the new flag. It also holds a level-mode pin active while writing a clear, to show that the condition re-asserts. Finally, it masks the enable while a sticky bit is set, to show the status survives the mask.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int unsigned REG_DATA_W = 32;

   // byte offsets decoded by software drivers
   localparam int unsigned OFS_PIN  = 32'h00;
   localparam int unsigned OFS_DIR  = 32'h04;
   localparam int unsigned OFS_IEN  = 32'h08;
   localparam int unsigned OFS_STAT = 32'h0C;
   localparam int unsigned OFS_PEND = 32'h10;
   localparam int unsigned OFS_CLR  = 32'h14;
   localparam int unsigned OFS_MODE = 32'h18;
   localparam int unsigned OFS_POL  = 32'h1C;
   localparam int unsigned OFS_VER  = 32'h20;
   localparam int unsigned OFS_BOTH = 32'h24;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_PIN, SEL_DIR, SEL_IEN, SEL_STAT, SEL_PEND,
      SEL_CLR, SEL_MODE, SEL_POL, SEL_VER, SEL_BOTH
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [31:0] a);
      reg_sel_e s;
      case (a)
         OFS_PIN:  s = SEL_PIN;
         OFS_DIR:  s = SEL_DIR;
         OFS_IEN:  s = SEL_IEN;
         OFS_STAT: s = SEL_STAT;
         OFS_PEND: s = SEL_PEND;
         OFS_CLR:  s = SEL_CLR;
         OFS_MODE: s = SEL_MODE;
         OFS_POL:  s = SEL_POL;
         OFS_VER:  s = SEL_VER;
         OFS_BOTH: s = SEL_BOTH;
         default:  s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= d_async;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_trig_unit.sv
module gpio_trig_unit #(
   parameter int unsigned NUM_PINS      = 32,
   parameter bit          HAS_BOTH_EDGE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] lvl_now,
   input  logic [NUM_PINS-1:0] mode_edge,
   input  logic [NUM_PINS-1:0] pol_high,
   input  logic [NUM_PINS-1:0] both_sel,
   input  logic                clr_stb,
   input  logic [NUM_PINS-1:0] clr_mask,
   output logic [NUM_PINS-1:0] status
);

   logic [NUM_PINS-1:0] lvl_prev_q;
   logic [NUM_PINS-1:0] edge_flag_q;
   logic [NUM_PINS-1:0] edge_hit;
   logic [NUM_PINS-1:0] clr_eff;

   assign clr_eff = clr_stb ? clr_mask : '0;

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         logic rise, fall, single_hit;
         assign rise       = lvl_now[p] & ~lvl_prev_q[p];
         assign fall       = ~lvl_now[p] & lvl_prev_q[p];
         assign single_hit = pol_high[p] ? rise : fall;
         if (HAS_BOTH_EDGE) begin : g_both
            assign edge_hit[p] = mode_edge[p] & (both_sel[p] ? (rise | fall) : single_hit);
         end else begin : g_single
            assign edge_hit[p] = mode_edge[p] & single_hit;
         end
         assign status[p] = mode_edge[p] ? edge_flag_q[p]
                                         : (pol_high[p] ? lvl_now[p] : ~lvl_now[p]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev_q  <= '0;
         edge_flag_q <= '0;
      end else begin
         lvl_prev_q  <= lvl_now;
         edge_flag_q <= edge_hit | (edge_flag_q & ~clr_eff);
      end
   end

   // R5
   edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|edge_hit) |=> ((edge_flag_q & $past(edge_hit)) == $past(edge_hit)));

   // R7
   clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> ((edge_flag_q & $past(clr_mask & ~edge_hit)) == '0));

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS      = 32,
   parameter int unsigned ADDR_W        = 6,
   parameter int unsigned VERSION       = 3,
   parameter bit          HAS_BOTH_EDGE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [REG_DATA_W-1:0] bus_wdata,
   output logic [REG_DATA_W-1:0] bus_rdata,
   input  logic [NUM_PINS-1:0]   pin_sync,
   input  logic [NUM_PINS-1:0]   status,
   output logic [NUM_PINS-1:0]   out_q,
   output logic [NUM_PINS-1:0]   dir_q,
   output logic [NUM_PINS-1:0]   mode_q,
   output logic [NUM_PINS-1:0]   pol_q,
   output logic [NUM_PINS-1:0]   both_q,
   output logic [NUM_PINS-1:0]   pend,
   output logic                  clr_stb,
   output logic [NUM_PINS-1:0]   clr_mask
);

   localparam logic [NUM_PINS-1:0] DIR_RST = '1;

   reg_sel_e            sel;
   logic [NUM_PINS-1:0] wvec;
   logic [NUM_PINS-1:0] ien_q;
   logic [NUM_PINS-1:0] rd_vec;

   assign sel      = decode_addr(32'(bus_addr));
   assign wvec     = bus_wdata[NUM_PINS-1:0];
   assign clr_stb  = bus_we && (sel == SEL_CLR);
   assign clr_mask = wvec;
   assign pend     = status & ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= DIR_RST;
         ien_q  <= '0;
         mode_q <= '0;
         pol_q  <= '0;
      end else if (bus_we) begin
         case (sel)
            SEL_PIN:  out_q  <= wvec;
            SEL_DIR:  dir_q  <= wvec;
            SEL_IEN:  ien_q  <= wvec;
            SEL_MODE: mode_q <= wvec;
            SEL_POL:  pol_q  <= wvec;
            default:  ;
         endcase
      end
   end

   generate
      if (HAS_BOTH_EDGE) begin : g_both_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          both_q <= '0;
            else if (bus_we && sel == SEL_BOTH)  both_q <= wvec;
         end
      end else begin : g_no_both
         assign both_q = '0;
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_PIN:  rd_vec = (dir_q & pin_sync) | (~dir_q & out_q);
         SEL_DIR:  rd_vec = dir_q;
         SEL_IEN:  rd_vec = ien_q;
         SEL_STAT: rd_vec = status;
         SEL_PEND: rd_vec = pend;
         SEL_MODE: rd_vec = mode_q;
         SEL_POL:  rd_vec = pol_q;
         SEL_BOTH: rd_vec = both_q;
         default:  rd_vec = '0;
      endcase
      bus_rdata = '0;
      bus_rdata[NUM_PINS-1:0] = rd_vec;
      if (sel == SEL_VER) bus_rdata = REG_DATA_W'(VERSION);
   end

   // R2
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && sel == SEL_DIR) |=> $stable(dir_q));

   // R9
   ver_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_VER) |-> (bus_rdata == REG_DATA_W'(VERSION)));

   // R10
   hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (bus_rdata == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS      = 32,
   parameter int unsigned ADDR_W        = 6,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned VERSION       = 3,
   parameter bit          HAS_BOTH_EDGE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [REG_DATA_W-1:0] bus_wdata,
   output logic [REG_DATA_W-1:0] bus_rdata,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pin_out,
   output logic [NUM_PINS-1:0]   pin_oe,
   output logic                  irq
);

   generate
      if (NUM_PINS < 1 || NUM_PINS > REG_DATA_W) begin : g_bad_pins
         $error("gpio_irq_ctrl: NUM_PINS must be 1..32");
      end
      if (ADDR_W < 6 || ADDR_W > 32) begin : g_bad_addr
         $error("gpio_irq_ctrl: ADDR_W must be 6..32");
      end
      if (HAS_BOTH_EDGE && VERSION < 3) begin : g_bad_ver
         $error("gpio_irq_ctrl: both-edge detection needs VERSION >= 3");
      end
   endgenerate

   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] status;
   logic [NUM_PINS-1:0] out_q, dir_q, mode_q, pol_q, both_q, pend, clr_mask;
   logic                clr_stb;

   gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (pin_sync)
   );

   gpio_trig_unit #(.NUM_PINS(NUM_PINS), .HAS_BOTH_EDGE(HAS_BOTH_EDGE)) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_now   (pin_sync),
      .mode_edge (mode_q),
      .pol_high  (pol_q),
      .both_sel  (both_q),
      .clr_stb   (clr_stb),
      .clr_mask  (clr_mask),
      .status    (status)
   );

   gpio_reg_file #(
      .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W),
      .VERSION(VERSION), .HAS_BOTH_EDGE(HAS_BOTH_EDGE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_sync  (pin_sync),
      .status    (status),
      .out_q     (out_q),
      .dir_q     (dir_q),
      .mode_q    (mode_q),
      .pol_q     (pol_q),
      .both_q    (both_q),
      .pend      (pend),
      .clr_stb   (clr_stb),
      .clr_mask  (clr_mask)
   );

   assign pin_out = out_q;
   assign pin_oe  = ~dir_q;
   assign irq     = |pend;

   // R8
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> !irq);

   // R2
   oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & dir_q) == '0));

endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;

   localparam int NP = 24;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic          irq;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // behavioural reference state
   logic [NP-1:0] m_out, m_dir, m_ien, m_mode, m_pol, m_both, m_flag;
   logic [NP-1:0] m_s1, m_s2, m_prev;
   logic [NP-1:0] t_rise, t_fall, t_hit, t_clr;
   bit            started = 0;

   function automatic logic [NP-1:0] m_status();
      logic [NP-1:0] s;
      for (int i = 0; i < NP; i++)
         s[i] = m_mode[i] ? m_flag[i] : (m_pol[i] ? m_s2[i] : ~m_s2[i]);
      return s;
   endfunction

   function automatic logic [31:0] m_read(input logic [AW-1:0] a);
      logic [NP-1:0] v;
      case (a)
         6'h00: v = (m_dir & m_s2) | (~m_dir & m_out);
         6'h04: v = m_dir;
         6'h08: v = m_ien;
         6'h0C: v = m_status();
         6'h10: v = m_status() & m_ien;
         6'h18: v = m_mode;
         6'h1C: v = m_pol;
         6'h24: v = m_both;
         6'h20: return 32'd3;
         default: v = '0;
      endcase
      return {{(32-NP){1'b0}}, v};
   endfunction

   function automatic string reg_tag(input logic [AW-1:0] a);
      case (a)
         6'h00: return "R3 value";
         6'h04: return "R2 direction";
         6'h08: return "R8 enable";
         6'h0C: return "R4 status";
         6'h10: return "R8 pending";
         6'h18, 6'h1C, 6'h24: return "R6 trigger config";
         6'h20: return "R9 version";
         default: return "R10 hole";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_out = '0; m_dir = '1; m_ien = '0; m_mode = '0; m_pol = '0;
         m_both = '0; m_flag = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
      end else begin
         t_rise = m_s2 & ~m_prev;
         t_fall = ~m_s2 & m_prev;
         t_hit  = '0;
         for (int i = 0; i < NP; i++) begin
            if (m_mode[i]) begin
               if (m_both[i]) t_hit[i] = t_rise[i] | t_fall[i];
               else if (m_pol[i]) t_hit[i] = t_rise[i];
               else t_hit[i] = t_fall[i];
            end
         end
         t_clr  = (we && addr == 6'h14) ? wdata[NP-1:0] : '0;
         m_flag = t_hit | (m_flag & ~t_clr);
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = pin_in;
         if (we) begin
            case (addr)
               6'h00: m_out  = wdata[NP-1:0];
               6'h04: m_dir  = wdata[NP-1:0];
               6'h08: m_ien  = wdata[NP-1:0];
               6'h18: m_mode = wdata[NP-1:0];
               6'h1C: m_pol  = wdata[NP-1:0];
               6'h24: m_both = wdata[NP-1:0];
               default: ;
            endcase
         end
      end
      started = 1;
      #2;
      chk(reg_tag(addr), rdata, m_read(addr));
      chk("R2 pin_oe", {8'h0, pin_oe}, {8'h0, ~m_dir});
      chk("R2 pin_out", {8'h0, pin_out}, {8'h0, m_out});
      chk("R8 irq", {31'h0, irq}, {31'h0, |(m_status() & m_ien)});
   end

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [AW-1:0] a,
                         input logic [31:0] mask, input logic [31:0] exp);
      @(negedge clk);
      addr = a;
      #1 chk(tag, rdata & mask, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      rd_chk("R1 dir reset", 6'h04, 32'hFFFF_FFFF, 32'h00FF_FFFF);
      rd_chk("R1 enable reset", 6'h08, 32'hFFFF_FFFF, 32'h0);
      rd_chk("R1 mode reset", 6'h18, 32'hFFFF_FFFF, 32'h0);
      chk("R1 irq reset", {31'h0, irq}, 32'h0);
      rd_chk("R9 version", 6'h20, 32'hFFFF_FFFF, 32'd3);
      rd_chk("R4 active-low level at reset", 6'h0C, 32'hFFFF_FFFF, 32'h00FF_FFFF);

      // R2 / R3 outputs and value read
      wr(6'h04, 32'h00FF_FF00);
      wr(6'h00, 32'h0000_00A5);
      #1;
      chk("R2 oe", {8'h0, pin_oe}, 32'h0000_00FF);
      chk("R2 out", {8'h0, pin_out}, 32'h0000_00A5);
      pin_in = 24'h12345A;
      idle(3);
      rd_chk("R3 mixed value", 6'h00, 32'hFFFF_FFFF, 32'h0012_34A5);
      wr(6'h04, 32'hFFFF_FFFF);
      rd_chk("R9 upper bits zero", 6'h04, 32'hFFFF_FFFF, 32'h00FF_FFFF);
      pin_in = '0;
      idle(3);

      // R5 rising edge on pin 0
      wr(6'h1C, 32'h1);
      wr(6'h18, 32'h1);
      rd_chk("R5 no edge yet", 6'h0C, 32'h1, 32'h0);
      pin_in[0] = 1'b1;
      idle(4);
      rd_chk("R5 rising sets", 6'h0C, 32'h1, 32'h1);
      pin_in[0] = 1'b0;
      idle(4);
      rd_chk("R5 sticky", 6'h0C, 32'h1, 32'h1);
      wr(6'h14, 32'h0);
      rd_chk("R7 zero clear no effect", 6'h0C, 32'h1, 32'h1);
      wr(6'h14, 32'h1);
      rd_chk("R7 one clears", 6'h0C, 32'h1, 32'h0);

      // R5 falling edge on pin 1
      wr(6'h18, 32'h3);
      pin_in[1] = 1'b1;
      idle(4);
      rd_chk("R5 rise ignored on falling pin", 6'h0C, 32'h2, 32'h0);
      pin_in[1] = 1'b0;
      idle(4);
      rd_chk("R5 falling sets", 6'h0C, 32'h2, 32'h2);

      // R6 both edges on pin 2
      wr(6'h24, 32'h4);
      wr(6'h18, 32'h7);
      pin_in[2] = 1'b1;
      idle(4);
      rd_chk("R6 rise sets", 6'h0C, 32'h4, 32'h4);
      wr(6'h14, 32'h4);
      rd_chk("R6 cleared", 6'h0C, 32'h4, 32'h0);
      pin_in[2] = 1'b0;
      idle(4);
      rd_chk("R6 fall sets", 6'h0C, 32'h4, 32'h4);
      wr(6'h14, 32'h4);

      // R4 active-high level on pin 3
      wr(6'h1C, 32'h9);
      pin_in[3] = 1'b1;
      idle(3);
      rd_chk("R4 level high", 6'h0C, 32'h8, 32'h8);
      wr(6'h14, 32'h8);
      rd_chk("R4 clear does not drop level", 6'h0C, 32'h8, 32'h8);
      pin_in[3] = 1'b0;
      idle(3);
      rd_chk("R4 level gone", 6'h0C, 32'h8, 32'h0);

      // R8 enable gating (pin 1 flag still set)
      wr(6'h08, 32'h2);
      #1 chk("R8 irq on", {31'h0, irq}, 32'h1);
      rd_chk("R8 pending", 6'h10, 32'hFFFF_FFFF, 32'h2);
      wr(6'h08, 32'h0);
      #1 chk("R8 irq masked", {31'h0, irq}, 32'h0);
      rd_chk("R8 status kept", 6'h0C, 32'h2, 32'h2);
      wr(6'h08, 32'h2);
      #1 chk("R8 irq back", {31'h0, irq}, 32'h1);
      wr(6'h14, 32'h2);
      #1 chk("R8 irq after clear", {31'h0, irq}, 32'h0);

      // R7 edge and clear in the same cycle: set wins
      @(negedge clk);
      pin_in[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      addr = 6'h14; wdata = 32'h1; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      rd_chk("R7 set wins over clear", 6'h0C, 32'h1, 32'h1);

      // R9 read-only registers
      wr(6'h0C, 32'h0);
      wr(6'h10, 32'h0);
      wr(6'h20, 32'h0);
      rd_chk("R9 status write ignored", 6'h0C, 32'h1, 32'h1);
      rd_chk("R9 version write ignored", 6'h20, 32'hFFFF_FFFF, 32'd3);

      // R10 holes and misaligned addresses
      rd_chk("R10 unmapped", 6'h3C, 32'hFFFF_FFFF, 32'h0);
      rd_chk("R10 misaligned", 6'h02, 32'hFFFF_FFFF, 32'h0);
      wr(6'h06, 32'h0);
      rd_chk("R10 misaligned write ignored", 6'h04, 32'hFFFF_FFFF, 32'h00FF_FFFF);

      idle(4);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule